// File: doc/BRIEF.md
# One-Hot Statement Sequencer

This block runs one fixed little program in hardware. Every statement of the program is compiled into its own enable flip-flop. Together these flip-flops form a control chain in which a single token travels, one statement per clock cycle. Each program variable (`x`, `y`, `z` and a loop counter) is a register. A variable loads only in the cycle where the statement that writes it holds the token. When a variable is written by several statements, a multiplexer at its input is steered by those statements' enables.

The program is: `y := x+1; z := y<<1; x := z^KEY; IF b THEN y := x+1 ELSE z := z^KEY; IF b THEN z := x+1; c := 0; REPEAT x := x+1, c := c+1 UNTIL c = LIMIT; c := (b ? LIMIT : 0); WHILE c /= LIMIT DO y := y+1, c := c+1; done`.
The condition `b` is the `cond` input. It is sampled in the cycles where a test or the second counter initialisation holds the token. A one-cycle `start` pulse loads `x_in` into `x` and places the token on the first statement. The token parks on the final statement, which drives `done`, until the next `start`.

All pins are plain control and status signals. There is no streaming data interface, so no valid/ready handshake or back-pressure applies.

Top module: `stmt_seq_engine`

## Requirements
- R1: After reset, every statement enable is 0, `done` is 0, and `x_out`, `y_out` and `z_out` are 0.
- R2: A `start` sampled high loads `x_in` into `x` and puts the token on the first statement, in every state. A `start` during a run aborts that run, and only the new run completes.
- R3: At most one statement enable is high at any time, and once started exactly one stays high.
- R4: The three sequential statements run in consecutive cycles: `y := x+1`, then `z := y<<1` (8-bit, truncated), then `x := z ^ KEY` (KEY default 8'hA5).
- R5: At the two-way test, `cond`=1 runs `y := x+1` and `cond`=0 runs `z := z ^ KEY`. Exactly one of the two branches takes the next cycle.
- R6: At the one-armed test, `cond`=1 runs `z := x+1` in one extra cycle. `cond`=0 skips to the successor with no cycle spent, and `z` is not loaded.
- R7: The post-tested loop clears the counter, then runs its body (`x := x+1`, counter +1) until the counter equals LIMIT after a body pass. The body therefore runs exactly LIMIT times (LIMIT >= 1).
- R8: The pre-tested loop sets the counter to LIMIT if `cond`=1 and to 0 otherwise, then tests before each body pass (`y := y+1`, counter +1). With `cond`=1 the body runs zero times; with `cond`=0 it runs LIMIT times.
- R9: `y` and `z` change only in cycles where a statement assigning them holds the token.
- R10: `done` is high exactly while the final statement holds the token. It first rises 10+LIMIT cycles after the `start` edge when `cond`=1, and 9+3*LIMIT cycles after it when `cond`=0. It then stays high with all outputs stable until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for all data and control registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse: load `x_in` and launch the token |
| x_in | input | W | Initial value of `x` |
| cond | input | 1 | Boolean condition `b` used by the tests |
| x_out | output | W | Register `x` |
| y_out | output | W | Register `y` |
| z_out | output | W | Register `z` |
| done | output | 1 | High while the final statement holds the token |

## Verification
The bench builds the block with W=8, KEY=8'hA5 and LIMIT=3. A small LIMIT keeps each run short, yet both loops still iterate several times. The done latency also differs clearly between the two `cond` settings (13 versus 18 cycles), so a token that skips or repeats one statement changes the measured cycle count. Several `x_in` values, including 8'hFF, exercise the truncating shift and the wrap of the increments. A restart issued mid-run checks that the earlier token is discarded.

// File: rtl/stmt_seq_pkg.sv
package stmt_seq_pkg;
  // Token positions of the compiled program; the chain order is behaviour.
  localparam int ST_Y     = 0;   // y := x+1
  localparam int ST_Z     = 1;   // z := y<<1
  localparam int ST_X     = 2;   // x := z^KEY
  localparam int ST_IF2   = 3;   // two-way test
  localparam int ST_THEN  = 4;   // y := x+1
  localparam int ST_ELSE  = 5;   // z := z^KEY
  localparam int ST_IF1   = 6;   // one-armed test
  localparam int ST_OPT   = 7;   // z := x+1
  localparam int ST_RINIT = 8;   // c := 0
  localparam int ST_RBODY = 9;   // x := x+1, c := c+1
  localparam int ST_WINIT = 10;  // c := b ? LIMIT : 0
  localparam int ST_WTEST = 11;  // pre-test
  localparam int ST_WBODY = 12;  // y := y+1, c := c+1
  localparam int ST_DONE  = 13;  // final, token parks here
  localparam int NUM_ST   = 14;
endpackage

// File: rtl/stmt_seq_ctrl.sv
module stmt_seq_ctrl
  import stmt_seq_pkg::*;
#(
  parameter int NS = NUM_ST
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          cond,
  input  logic          rep_exit,
  input  logic          wh_exit,
  output logic [NS-1:0] en
);
  logic [NS-1:0] nxt;

  always_comb begin
    nxt           = '0;
    nxt[ST_Z]     = en[ST_Y];
    nxt[ST_X]     = en[ST_Z];
    nxt[ST_IF2]   = en[ST_X];
    nxt[ST_THEN]  = en[ST_IF2] & cond;
    nxt[ST_ELSE]  = en[ST_IF2] & ~cond;
    nxt[ST_IF1]   = en[ST_THEN] | en[ST_ELSE];
    nxt[ST_OPT]   = en[ST_IF1] & cond;
    nxt[ST_RINIT] = (en[ST_IF1] & ~cond) | en[ST_OPT];
    nxt[ST_RBODY] = en[ST_RINIT] | (en[ST_RBODY] & ~rep_exit);
    nxt[ST_WINIT] = en[ST_RBODY] & rep_exit;
    nxt[ST_WTEST] = en[ST_WINIT] | en[ST_WBODY];
    nxt[ST_WBODY] = en[ST_WTEST] & ~wh_exit;
    nxt[ST_DONE]  = (en[ST_WTEST] & wh_exit) | en[ST_DONE];
  end

  for (genvar i = 0; i < NS; i++) begin : g_en
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     en[i] <= 1'b0;
      else if (start) en[i] <= (i == ST_Y);
      else            en[i] <= nxt[i];
    end
  end

  AST_TWO_WAY_ONE_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
    (en[ST_IF2] && !start) |=> (en[ST_THEN] ^ en[ST_ELSE])); // R5
  AST_SEQ_Y_THEN_Z: assert property (@(posedge clk) disable iff (!rst_n)
    (en[ST_Y] && !start) |=> en[ST_Z]); // R4
  AST_SEQ_Z_THEN_X: assert property (@(posedge clk) disable iff (!rst_n)
    (en[ST_Z] && !start) |=> en[ST_X]); // R4
  AST_SKIP_NO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (en[ST_IF1] && !cond && !start) |=> en[ST_RINIT]); // R6
endmodule

// File: rtl/stmt_seq_loopcnt.sv
module stmt_seq_loopcnt #(
  parameter int LIMIT = 4,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic init,
  input  logic fill,
  input  logic inc,
  output logic at_lim,
  output logic next_at_lim
);
  logic [CW-1:0] cnt;
  logic [CW:0]   cnt_inc;

  assign cnt_inc     = {1'b0, cnt} + (CW+1)'(1);
  assign at_lim      = ({1'b0, cnt} == (CW+1)'(LIMIT));
  assign next_at_lim = (cnt_inc == (CW+1)'(LIMIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (init) cnt <= fill ? CW'(LIMIT) : '0;
    else if (inc)  cnt <= cnt_inc[CW-1:0];
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, cnt} <= (CW+1)'(LIMIT)); // R7
  AST_CNT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0)); // R7
endmodule

// File: rtl/stmt_seq_datapath.sv
module stmt_seq_datapath #(
  parameter int W = 8,
  parameter logic [W-1:0] KEY = W'('hA5)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] x_in,
  input  logic         e_y,
  input  logic         e_z,
  input  logic         e_x,
  input  logic         e_then,
  input  logic         e_else,
  input  logic         e_opt,
  input  logic         e_rbody,
  input  logic         e_wbody,
  output logic [W-1:0] x_q,
  output logic [W-1:0] y_q,
  output logic [W-1:0] z_q
);
  logic [W-1:0] f_x, g_y, h_z, y_inc, z_key;

  assign f_x   = x_q + W'(1);
  assign g_y   = {y_q[W-2:0], 1'b0};
  assign h_z   = z_q ^ KEY;
  assign y_inc = y_q + W'(1);
  assign z_key = z_q ^ KEY;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       x_q <= '0;
    else if (start)   x_q <= x_in;
    else if (e_x)     x_q <= h_z;
    else if (e_rbody) x_q <= f_x;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                y_q <= '0;
    else if (e_y || e_then)    y_q <= f_x;
    else if (e_wbody)          y_q <= y_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      z_q <= '0;
    else if (e_z)    z_q <= g_y;
    else if (e_else) z_q <= z_key;
    else if (e_opt)  z_q <= f_x;
  end

  AST_START_LOADS_X: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (x_q == $past(x_in))); // R2
  AST_Y_ONLY_ON_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(e_y || e_then || e_wbody) |=> $stable(y_q)); // R9
  AST_Z_ONLY_ON_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(e_z || e_else || e_opt) |=> $stable(z_q)); // R9
endmodule

// File: rtl/stmt_seq_engine.sv
module stmt_seq_engine
  import stmt_seq_pkg::*;
#(
  parameter int W = 8,
  parameter logic [W-1:0] KEY = W'('hA5),
  parameter int LIMIT = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] x_in,
  input  logic         cond,
  output logic [W-1:0] x_out,
  output logic [W-1:0] y_out,
  output logic [W-1:0] z_out,
  output logic         done
);
  logic [NUM_ST-1:0] en;
  logic rep_exit, wh_exit;

  stmt_seq_ctrl #(.NS(NUM_ST)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .cond(cond),
    .rep_exit(rep_exit), .wh_exit(wh_exit), .en(en)
  );

  stmt_seq_loopcnt #(.LIMIT(LIMIT)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .clr(en[ST_RINIT]), .init(en[ST_WINIT]), .fill(cond),
    .inc(en[ST_RBODY] | en[ST_WBODY]),
    .at_lim(wh_exit), .next_at_lim(rep_exit)
  );

  stmt_seq_datapath #(.W(W), .KEY(KEY)) u_dp (
    .clk(clk), .rst_n(rst_n), .start(start), .x_in(x_in),
    .e_y(en[ST_Y]), .e_z(en[ST_Z]), .e_x(en[ST_X]),
    .e_then(en[ST_THEN]), .e_else(en[ST_ELSE]), .e_opt(en[ST_OPT]),
    .e_rbody(en[ST_RBODY]), .e_wbody(en[ST_WBODY]),
    .x_q(x_out), .y_q(y_out), .z_q(z_out)
  );

  assign done = en[ST_DONE];

  AST_TOKEN_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(en)); // R3
  AST_TOKEN_NOT_LOST: assert property (@(posedge clk) disable iff (!rst_n)
    (|en) |=> ($countones(en) == 1)); // R3
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(x_out) && $stable(y_out) && $stable(z_out))); // R10
  AST_START_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!done && en[ST_Y])); // R2
endmodule

// File: tb/stmt_seq_engine_tb.sv
module stmt_seq_engine_tb;
  localparam int W = 8;
  localparam int LIM = 3;
  localparam logic [W-1:0] KEY = 8'hA5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [W-1:0] x_in = '0;
  logic cond = 1'b0;
  logic [W-1:0] x_out, y_out, z_out;
  logic done;

  always #5 clk = ~clk;

  stmt_seq_engine #(.W(W), .KEY(KEY), .LIMIT(LIM)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .x_in(x_in), .cond(cond),
    .x_out(x_out), .y_out(y_out), .z_out(z_out), .done(done)
  );

  typedef struct {
    logic [W-1:0] x, y, z;
    int lat;
  } exp_t;

  exp_t sb_q[$];
  int n_tests = 0;
  int n_fail = 0;
  int cyc = 0;
  int wd = 0;

  always @(posedge clk) cyc <= start ? 0 : cyc + 1;

  task automatic check(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic exp_t model(logic [W-1:0] x0, logic c);
    exp_t e;
    logic [W-1:0] x, y, z;
    x = x0;
    y = x + 8'd1;           // R4
    z = {y[W-2:0], 1'b0};
    x = z ^ KEY;
    if (c) y = x + 8'd1;    // R5
    else   z = z ^ KEY;
    if (c) z = x + 8'd1;    // R6
    x = x + 8'(LIM);        // R7
    if (!c) y = y + 8'(LIM);// R8
    e.x = x; e.y = y; e.z = z;
    e.lat = c ? 10 + LIM : 9 + 3 * LIM; // R10
    return e;
  endfunction

  task automatic launch(logic [W-1:0] x0, logic c, bit push);
    @(negedge clk);
    start = 1'b1; x_in = x0; cond = c;
    @(negedge clk);
    start = 1'b0;
    check("R2 done low after start", int'(done), 0);
    check("R2 x loaded", int'(x_out), int'(x0));
    if (push) sb_q.push_back(model(x0, c));
  endtask

  task automatic drain();
    while (sb_q.size() != 0) @(negedge clk);
  endtask

  // Monitor: pops one expected item when the token reaches the final statement
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0 && done) begin
        exp_t e;
        e = sb_q.pop_front();
        check("R4_R7 x", int'(x_out), int'(e.x));
        check("R5_R8 y", int'(y_out), int'(e.y));
        check("R5_R6 z", int'(z_out), int'(e.z));
        check("R10 latency", cyc, e.lat);
      end
    end
  end

  task automatic hold_check();
    logic [W-1:0] hx, hy, hz;
    hx = x_out; hy = y_out; hz = z_out;
    repeat (4) @(negedge clk);
    check("R10 done held", int'(done), 1);
    check("R10 x stable", int'(x_out), int'(hx));
    check("R10 y stable", int'(y_out), int'(hy));
    check("R9 z stable", int'(z_out), int'(hz));
  endtask

  initial begin
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 20000) begin
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=<20000", wd);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 done", int'(done), 0);
    check("R1 x", int'(x_out), 0);
    check("R1 y", int'(y_out), 0);
    check("R1 z", int'(z_out), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 idle no done", int'(done), 0);

    for (int k = 0; k < 4; k++) begin
      logic [W-1:0] xv;
      case (k)
        0: xv = 8'h00;
        1: xv = 8'h3C;
        2: xv = 8'hFF;
        default: xv = 8'h7A;
      endcase
      for (int c = 0; c < 2; c++) begin
        launch(xv, c[0], 1'b1);
        drain();
        hold_check();
      end
    end

    // R2: restart while a run is in flight; only the second run completes
    launch(8'h11, 1'b1, 1'b0);
    repeat (3) @(negedge clk);
    launch(8'h22, 1'b0, 1'b1);
    drain();
    hold_check();

    // R1: reset again after a run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 done after reset", int'(done), 0);
    check("R1 x after reset", int'(x_out), 0);
    check("R1 y after reset", int'(y_out), 0);
    check("R1 z after reset", int'(z_out), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule